// File: doc/BRIEF.md
# Clock Emergency-Mode Supervisor

This block sits beside the system clock generator and owns the output-divider setting that reaches it. When the main oscillator is lost, or the device wakes from sleep, the supervisor enters emergency mode. In that mode it forces the divider to its largest code (4'hF, divide by 16), so the core runs safely from the free-running VCO base frequency. While in emergency mode it counts strobes from the main oscillator. Once a parameterised number of ticks has arrived (2048 by default), it declares oscillator lock, loads the divider that software last programmed and leaves emergency mode.

Software writes a target divider and a bypass control bit. A divider write takes effect at once, even during emergency mode. A bypass write during emergency mode is stored and only applied when lock is declared. A one-cycle unlock flag marks the loss of an established lock caused by an oscillator failure. A wake-up never raises it.

While emergency reconfiguration is in progress the block reports busy. During that time a power-down request is held back, and it is granted only once busy has dropped.

Top module: `clk_emg_sup`

## Requirements
- R1: After reset, div_o is 4'hF, emerg_o and busy_o are 1, and osc_lock_o, bypass_o, unlock_o and pd_grant_o are 0.
- R2: An osc_fail_i or wake_i pulse sets div_o to 4'hF and emerg_o to 1 in the next cycle.
- R3: osc_lock_o rises in the cycle after the LOCK_TICKS-th osc_tick_i counted in emergency mode (2048 by default), and not earlier.
- R4: In the cycle osc_lock_o rises, emerg_o is 0 and div_o holds the target divider. A cfg_we_i in the completing cycle supplies that target.
- R5: Outside emergency mode, a cfg_we_i write appears on div_o and bypass_o in the next cycle.
- R6: During emergency mode, a write updates div_o in the next cycle, while bypass_o keeps its value until lock is declared.
- R7: A failure or wake-up clears the tick count and the lock, so a full LOCK_TICKS ticks are needed again. This holds even when the event coincides with the final tick, and the event wins.
- R8: unlock_o pulses for one cycle after osc_fail_i while osc_lock_o is 1. It stays 0 for a wake-up and for a failure while already unlocked.
- R9: A pd_req_i pulse while not busy yields a one-cycle pd_grant_o in the next cycle.
- R10: A pd_req_i while busy is held, with no grant while busy_o is 1. It is granted in the first cycle busy_o reads 0.
- R11: busy_o is 1 exactly while emerg_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle strobe per main oscillator tick |
| osc_fail_i | input | 1 | Oscillator failure indication |
| wake_i | input | 1 | Wake-up from sleep event |
| cfg_we_i | input | 1 | Software configuration write strobe |
| cfg_div_i | input | 4 | Target output divider code |
| cfg_bypass_i | input | 1 | Target bypass control |
| pd_req_i | input | 1 | Power-down entry request pulse |
| div_o | output | 4 | Effective output divider code |
| bypass_o | output | 1 | Effective bypass control |
| emerg_o | output | 1 | Emergency mode status |
| osc_lock_o | output | 1 | Oscillator lock status |
| busy_o | output | 1 | Reconfiguration in progress |
| unlock_o | output | 1 | One-cycle loss-of-lock flag |
| pd_grant_o | output | 1 | One-cycle power-down grant |

## Verification
Two functions can fall in the same cycle, and the bench targets both pairings. The first is lock completion meeting a software write or an oscillator failure. Directed cases place a write, and separately a failure, on exactly the 2048th tick. The judgement is whether the written value lands on the divider, and whether the failure wins and restarts the count. The second pairing is lock completion and a power-down request held during busy. Random stimulus then mixes ticks, writes, failures, wake-ups and requests, and the outputs are compared every cycle against a reference model built from the requirements.

// File: rtl/clk_emg_pkg.sv
package clk_emg_pkg;
  localparam int unsigned DIV_W = 4;
  typedef logic [DIV_W-1:0] div_t;
  localparam div_t DIV_EMERG = '1;  // divide by 16
endpackage

// File: rtl/clk_emg_lock_cnt.sv
module clk_emg_lock_cnt #(
  parameter int unsigned LOCK_TICKS = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic count_en_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = count_en_i & tick_i & (cnt_q == CNT_LAST) & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || !count_en_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);

  a_r7_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/clk_emg_div_ctrl.sv
module clk_emg_div_ctrl
  import clk_emg_pkg::*;
#(
  parameter div_t RST_TGT_DIV = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic done_i,
  input  logic emerg_i,
  input  logic cfg_we_i,
  input  div_t cfg_div_i,
  input  logic cfg_bypass_i,
  output div_t div_o,
  output logic bypass_o
);
  div_t tgt_div_q, div_q;
  logic tgt_byp_q, byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_div_q <= RST_TGT_DIV;
      tgt_byp_q <= 1'b0;
    end else if (cfg_we_i) begin
      tgt_div_q <= cfg_div_i;
      tgt_byp_q <= cfg_bypass_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_EMERG;
    end else if (restart_i) begin
      div_q <= DIV_EMERG;
    end else if (done_i) begin
      div_q <= cfg_we_i ? cfg_div_i : tgt_div_q;
    end else if (cfg_we_i) begin
      div_q <= cfg_div_i;  // effective at once, even in emergency
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
    end else if (restart_i) begin
      byp_q <= byp_q;
    end else if (done_i) begin
      byp_q <= cfg_we_i ? cfg_bypass_i : tgt_byp_q;
    end else if (cfg_we_i && !emerg_i) begin
      byp_q <= cfg_bypass_i;
    end
  end

  assign div_o    = div_q;
  assign bypass_o = byp_q;

  a_r6_bypass_deferred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emerg_i && !done_i) |=> $stable(bypass_o));

  a_r2_restart_div_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> div_o == DIV_EMERG);
endmodule

// File: rtl/clk_emg_pd_gate.sv
module clk_emg_pd_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  input  logic busy_next_i,
  output logic pd_grant_o
);
  logic pend_q, grant_q;
  logic want;

  assign want = pend_q | pd_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      pend_q  <= want & busy_next_i;
      grant_q <= want & ~busy_next_i;
    end
  end

  assign pd_grant_o = grant_q;

  a_r10_held_until_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (want && busy_next_i) |=> !pd_grant_o);
endmodule

// File: rtl/clk_emg_sup.sv
module clk_emg_sup
  import clk_emg_pkg::*;
#(
  parameter int unsigned LOCK_TICKS  = 2048,
  parameter div_t        RST_TGT_DIV = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             osc_fail_i,
  input  logic             wake_i,
  input  logic             cfg_we_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             cfg_bypass_i,
  input  logic             pd_req_i,
  output logic [DIV_W-1:0] div_o,
  output logic             bypass_o,
  output logic             emerg_o,
  output logic             osc_lock_o,
  output logic             busy_o,
  output logic             unlock_o,
  output logic             pd_grant_o
);
  logic restart, done, emerg_d;
  logic emerg_q, lock_q, unlock_q;

  assign restart = osc_fail_i | wake_i;
  assign emerg_d = restart | (emerg_q & ~done);

  clk_emg_lock_cnt #(.LOCK_TICKS(LOCK_TICKS)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .count_en_i (emerg_q),
    .tick_i     (osc_tick_i),
    .done_o     (done)
  );

  clk_emg_div_ctrl #(.RST_TGT_DIV(RST_TGT_DIV)) u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart),
    .done_i       (done),
    .emerg_i      (emerg_q),
    .cfg_we_i     (cfg_we_i),
    .cfg_div_i    (cfg_div_i),
    .cfg_bypass_i (cfg_bypass_i),
    .div_o        (div_o),
    .bypass_o     (bypass_o)
  );

  clk_emg_pd_gate u_pd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pd_req_i    (pd_req_i),
    .busy_next_i (emerg_d),
    .pd_grant_o  (pd_grant_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      emerg_q  <= 1'b1;
      lock_q   <= 1'b0;
      unlock_q <= 1'b0;
    end else begin
      emerg_q  <= emerg_d;
      unlock_q <= osc_fail_i & lock_q;  // wake-up raises no flag
      if (restart)   lock_q <= 1'b0;
      else if (done) lock_q <= 1'b1;
    end
  end

  assign emerg_o    = emerg_q;
  assign osc_lock_o = lock_q;
  assign busy_o     = emerg_q;
  assign unlock_o   = unlock_q;

  a_r2_enter_emerg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (emerg_o && !osc_lock_o));

  a_r4_lock_exits_emerg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_lock_o) |-> !emerg_o);

  a_r8_unlock_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |-> ($past(osc_fail_i) && $past(osc_lock_o)));

  a_r10_no_grant_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_grant_o |-> !busy_o);
endmodule

// File: tb/clk_emg_sup_tb.sv
module clk_emg_sup_tb_top;
  localparam int unsigned LT = 2048;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_tick_i = 0, osc_fail_i = 0, wake_i = 0, cfg_we_i = 0;
  logic [3:0] cfg_div_i = '0;
  logic cfg_bypass_i = 0, pd_req_i = 0;
  logic [3:0] div_o;
  logic bypass_o, emerg_o, osc_lock_o, busy_o, unlock_o, pd_grant_o;

  int n_chk = 0, n_fail = 0;

  // reference state
  int unsigned m_cnt;
  bit m_emerg, m_lock, m_byp, m_tbyp, m_pend, m_grant, m_unl;
  logic [3:0] m_div, m_tdiv;

  always #4 clk_i = ~clk_i;

  clk_emg_sup #(.LOCK_TICKS(LT)) dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_emerg = 1; m_lock = 0; m_byp = 0; m_tbyp = 0;
    m_pend = 0; m_grant = 0; m_unl = 0; m_div = 4'hF; m_tdiv = 4'h0;
  endtask

  task automatic model_step(input bit t, f, w, we, input logic [3:0] d, input bit b, p);
    bit rs, dn, ne, want;
    rs = f | w;
    dn = m_emerg & t & (m_cnt == LT - 1) & ~rs;
    ne = rs | (m_emerg & ~dn);
    want = m_pend | p;
    m_unl = f & m_lock;
    if (rs) m_div = 4'hF;
    else if (dn) m_div = we ? d : m_tdiv;
    else if (we) m_div = d;
    if (!rs) begin
      if (dn) m_byp = we ? b : m_tbyp;
      else if (we && !m_emerg) m_byp = b;
    end
    if (we) begin m_tdiv = d; m_tbyp = b; end
    if (rs || !m_emerg) m_cnt = 0;
    else if (t) m_cnt = dn ? 0 : m_cnt + 1;
    if (rs) m_lock = 0; else if (dn) m_lock = 1;
    m_grant = want & ~ne;
    m_pend = want & ne;
    m_emerg = ne;
  endtask

  task automatic cmp_model();
    chk("R2 R4 R6 model div", div_o, m_div);
    chk("R5 R6 model bypass", bypass_o, m_byp);
    chk("R2 model emerg", emerg_o, m_emerg);
    chk("R3 R7 model lock", osc_lock_o, m_lock);
    chk("R11 model busy", busy_o, m_emerg);
    chk("R8 model unlock", unlock_o, m_unl);
    chk("R9 R10 model grant", pd_grant_o, m_grant);
  endtask

  task automatic cyc(input bit t, f, w, we, input logic [3:0] d, input bit b, p);
    osc_tick_i = t; osc_fail_i = f; wake_i = w; cfg_we_i = we;
    cfg_div_i = d; cfg_bypass_i = b; pd_req_i = p;
    @(posedge clk_i);
    model_step(t, f, w, we, d, b, p);
    @(negedge clk_i);
    cmp_model();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 4'h0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 div", div_o, 4'hF);
    chk("R1 emerg", emerg_o, 1);
    chk("R1 busy", busy_o, 1);
    chk("R1 lock", osc_lock_o, 0);
    chk("R1 bypass", bypass_o, 0);
    chk("R1 unlock", unlock_o, 0);
    chk("R1 grant", pd_grant_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 write during emergency
    cyc(0, 0, 0, 1, 4'h5, 1, 0);
    chk("R6 div immediate", div_o, 4'h5);
    chk("R6 bypass deferred", bypass_o, 0);
    // R10 request while busy
    cyc(0, 0, 0, 0, 4'h0, 0, 1);
    chk("R10 no grant while busy", pd_grant_o, 0);
    ticks(LT - 1);
    chk("R3 no lock before last tick", osc_lock_o, 0);
    cyc(1, 0, 0, 0, 4'h0, 0, 0);
    chk("R3 lock after count", osc_lock_o, 1);
    chk("R4 emerg clear", emerg_o, 0);
    chk("R4 target div", div_o, 4'h5);
    chk("R6 bypass applied at lock", bypass_o, 1);
    chk("R10 grant when free", pd_grant_o, 1);
    chk("R11 busy low", busy_o, 0);
    cyc(0, 0, 0, 0, 4'h0, 0, 0);
    chk("R10 grant one cycle", pd_grant_o, 0);

    // R5 write when locked
    cyc(0, 0, 0, 1, 4'h3, 0, 0);
    chk("R5 div", div_o, 4'h3);
    chk("R5 bypass", bypass_o, 0);
    // R9 request when idle
    cyc(0, 0, 0, 0, 4'h0, 0, 1);
    chk("R9 grant next cycle", pd_grant_o, 1);

    // R8 failure from lock
    cyc(0, 1, 0, 0, 4'h0, 0, 0);
    chk("R2 fail div max", div_o, 4'hF);
    chk("R2 fail emerg", emerg_o, 1);
    chk("R8 unlock pulse", unlock_o, 1);
    cyc(0, 0, 0, 0, 4'h0, 0, 0);
    chk("R8 unlock one cycle", unlock_o, 0);

    // R7 restart mid-count and on the final tick
    ticks(1000);
    cyc(1, 1, 0, 0, 4'h0, 0, 0);
    chk("R8 no unlock when unlocked", unlock_o, 0);
    ticks(LT - 1);
    cyc(1, 1, 0, 0, 4'h0, 0, 0);
    chk("R7 fail wins final tick", osc_lock_o, 0);
    ticks(LT - 1);
    chk("R7 full recount needed", osc_lock_o, 0);
    cyc(1, 0, 0, 1, 4'h9, 0, 0);
    chk("R4 write on final tick", div_o, 4'h9);
    chk("R3 relock", osc_lock_o, 1);

    // wake-up from lock
    cyc(0, 0, 1, 0, 4'h0, 0, 0);
    chk("R8 no unlock on wake", unlock_o, 0);
    chk("R2 wake div max", div_o, 4'hF);
    chk("R11 busy on wake", busy_o, 1);

    // random mix
    for (int i = 0; i < 80000; i++) begin
      cyc($urandom % 2 == 0, $urandom % 5000 == 0, $urandom % 5000 == 0,
          $urandom % 60 == 0, 4'($urandom), 1'($urandom), $urandom % 40 == 0);
    end
    finish_run();
  end
endmodule